// File: doc/BRIEF.md
# Posted Write Latch with Read Stall

This block sits between a processor and a slow peripheral bus. It holds one posted write so the processor does not wait on it. When a write is accepted, it is sent on to the bus in the same cycle. Its data is also packed into a 32-bit latch, and an I/O busy flag is raised. The flag drops by itself after a fixed number of cycles (`DONE_CYCLES`, 100 by default). That count models how long the bus needs to finish the write.

While the flag is up, the block refuses any further write. A read in that window is not sent to the bus. Instead it is answered at once from the latch, with a slice chosen by the access size. The block then raises a stall output until the pending write would have finished. When the flag is down, reads pass straight to the bus and back with no stall.

Top module: `posted_write_latch`

## Requirements
- R1: A write request while the flag is down is accepted. `cpu_wr_ok` and `bus_req` are high in that same cycle. `io_busy` rises at the next clock edge and then stays high for exactly `DONE_CYCLES` cycles.
- R2: A write request while `io_busy` is high is rejected, and this includes the stall period. `cpu_wr_ok` and `bus_req` stay low and `latch_value` does not change.
- R3: An accepted byte write (size code 0) latches `wdata[7:0]` shifted left by 24 minus 8 times address bit 0. The byte lands in bits 31:24 for an even address and in bits 23:16 for an odd one. All other bits are zero.
- R4: An accepted write of size 1 (halfword) latches `{wdata[15:0], 16'h0}`. Size 2 (word) latches `wdata[31:0]`. Size 3 (doubleword) latches `wdata[63:32]`.
- R5: A read while the flag is up and no stall is running returns a slice of the latch on `cpu_rdata` in that cycle:
  - size 0: `latch[31:24]`, zero-extended;
  - size 1: `latch[31:16]`, zero-extended;
  - size 2: the full latch, zero-extended;
  - size 3: `{latch, 32'h0}`.
- R6: Such a read makes no bus request. Suppose `r` cycles of the busy window remain, counting the read cycle. Then `stall` is high for the `r-1` cycles that follow, and `stall` and `io_busy` fall at the same edge. That edge is the one at which `io_busy` would have fallen without the read. A read in the last busy cycle causes no stall.
- R7: A read while the flag is down is forwarded to the bus unchanged. `cpu_rdata` equals `bus_rdata`, and no stall follows.
- R8: After reset, `io_busy` and `stall` are low and `latch_value` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | 64 | Write data, right-aligned |
| cpu_rdata | output | 64 | Read data (latch slice or bus data) |
| cpu_wr_ok | output | 1 | Write accepted this cycle |
| bus_req | output | 1 | Request forwarded to the bus |
| bus_we | output | 1 | Forwarded direction |
| bus_size | output | 2 | Forwarded size |
| bus_addr | output | ADDR_W | Forwarded address |
| bus_wdata | output | 64 | Forwarded write data |
| bus_rdata | input | 64 | Bus read data |
| latch_value | output | 32 | Current latch contents |
| io_busy | output | 1 | Posted write still in flight |
| stall | output | 1 | Requester must wait |

## Verification
Each fault in the internal state shows up at the ports:
- A wrong remaining count moves the falling edge of `io_busy`. It shows up within the busy window, as a busy length other than `DONE_CYCLES` or a stall length other than `r-1`.
- A busy flag stuck high or low shows up on the next request. Either a write is refused when it should be taken, or a read reaches the bus when it should not.
- A wrong latch placement shows up one cycle after the write, on `latch_value`.
- A wrong read slice shows up in the read cycle itself, on `cpu_rdata`.

The sweep covers every size against every read offset in a short busy window.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
    localparam int LATCH_W = 32;
    localparam int XFER_W  = 64;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } xfer_size_e;
endpackage

// File: rtl/pwl_pack.sv
module pwl_pack
    import pwl_pkg::*;
(
    input  logic [1:0]         size,
    input  logic               addr_lsb,
    input  logic [XFER_W-1:0]  wdata,
    output logic [LATCH_W-1:0] latch_word
);
    always_comb begin
        unique case (xfer_size_e'(size))
            SZ_BYTE:  latch_word = addr_lsb ? {8'h00, wdata[7:0], 16'h0000}
                                            : {wdata[7:0], 24'h000000};
            SZ_HALF:  latch_word = {wdata[15:0], 16'h0000};
            SZ_WORD:  latch_word = wdata[31:0];
            default:  latch_word = wdata[63:32];
        endcase
    end
endmodule

// File: rtl/pwl_slice.sv
module pwl_slice
    import pwl_pkg::*;
(
    input  logic [1:0]         size,
    input  logic [LATCH_W-1:0] latch_word,
    output logic [XFER_W-1:0]  rdata
);
    always_comb begin
        unique case (xfer_size_e'(size))
            SZ_BYTE:  rdata = {56'h0, latch_word[31:24]};
            SZ_HALF:  rdata = {48'h0, latch_word[31:16]};
            SZ_WORD:  rdata = {32'h0, latch_word};
            default:  rdata = {latch_word, 32'h0};
        endcase
    end
endmodule

// File: rtl/posted_write_latch.sv
module posted_write_latch
    import pwl_pkg::*;
#(
    parameter int DONE_CYCLES = 100,
    parameter int ADDR_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [63:0]       cpu_wdata,
    output logic [63:0]       cpu_rdata,
    output logic              cpu_wr_ok,
    output logic              bus_req,
    output logic              bus_we,
    output logic [1:0]        bus_size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [63:0]       bus_wdata,
    input  logic [63:0]       bus_rdata,
    output logic [31:0]       latch_value,
    output logic              io_busy,
    output logic              stall
);
    localparam int CNT_W = $clog2(DONE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DONE_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    typedef struct packed {
        logic               busy;
        logic               stall;
        logic [CNT_W-1:0]   remain;
        logic [LATCH_W-1:0] latch;
    } pwl_state_t;

    pwl_state_t st_d, st_q;

    logic [LATCH_W-1:0] packed_word;
    logic [XFER_W-1:0]  latch_slice;
    logic               wr_take, rd_idle, rd_hit;

    pwl_pack u_pack (
        .size       (cpu_size),
        .addr_lsb   (cpu_addr[0]),
        .wdata      (cpu_wdata),
        .latch_word (packed_word)
    );

    pwl_slice u_slice (
        .size       (cpu_size),
        .latch_word (st_q.latch),
        .rdata      (latch_slice)
    );

    always_comb begin
        wr_take = cpu_req && cpu_we && !st_q.busy;
        rd_idle = cpu_req && !cpu_we && !st_q.busy;
        rd_hit  = cpu_req && !cpu_we && st_q.busy && !st_q.stall;

        st_d = st_q;
        if (st_q.busy) begin
            st_d.remain = st_q.remain - CNT_LAST;
            if (st_q.remain == CNT_LAST) begin
                st_d.busy  = 1'b0;
                st_d.stall = 1'b0;
            end
        end
        if (rd_hit && st_q.remain != CNT_LAST) begin
            st_d.stall = 1'b1;
        end
        if (wr_take) begin
            st_d.busy   = 1'b1;
            st_d.remain = CNT_LOAD;
            st_d.latch  = packed_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_wr_ok   = wr_take;
    assign bus_req     = wr_take || rd_idle;
    assign bus_we      = cpu_we;
    assign bus_size    = cpu_size;
    assign bus_addr    = cpu_addr;
    assign bus_wdata   = cpu_wdata;
    assign cpu_rdata   = rd_hit ? latch_slice : bus_rdata;
    assign latch_value = st_q.latch;
    assign io_busy     = st_q.busy;
    assign stall       = st_q.stall;

    // R1
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_busy) |-> $past(cpu_wr_ok));

    // R1
    remain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_busy |-> (st_q.remain != '0 && st_q.remain <= CNT_LOAD));

    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_busy && cpu_req && cpu_we) |=> $stable(latch_value));

    // R2
    busy_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_busy |-> !bus_req);

    // R6
    stall_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> io_busy);

    // R6
    stall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> !io_busy);

    // R7
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && !io_busy) |=> !stall);
endmodule

// File: tb/posted_write_latch_bench.sv
module posted_write_latch_bench;
    localparam int N = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [31:0] cpu_addr = '0;
    logic [63:0] cpu_wdata = '0;
    logic [63:0] cpu_rdata;
    logic        cpu_wr_ok;
    logic        bus_req, bus_we;
    logic [1:0]  bus_size;
    logic [31:0] bus_addr;
    logic [63:0] bus_wdata;
    logic [63:0] bus_rdata;
    logic [31:0] latch_value;
    logic        io_busy, stall;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    assign bus_rdata = {bus_addr, ~bus_addr};

    posted_write_latch #(.DONE_CYCLES(N), .ADDR_W(32)) u_posted_write_latch (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_wr_ok(cpu_wr_ok), .bus_req(bus_req),
        .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .latch_value(latch_value), .io_busy(io_busy), .stall(stall)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_latch(input int s, input bit a0, input logic [63:0] d);
        case (s)
            0: return 32'(d[7:0]) << (24 - 8 * int'(a0));
            1: return {d[15:0], 16'h0};
            2: return d[31:0];
            default: return d[63:32];
        endcase
    endfunction

    function automatic logic [63:0] exp_slice(input int s, input logic [31:0] l);
        case (s)
            0: return {56'h0, l[31:24]};
            1: return {48'h0, l[31:16]};
            2: return {32'h0, l};
            default: return {l, 32'h0};
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R1 watchdog actual=hang expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        logic [31:0] lat;
        logic [63:0] d;
        int bc, sc;
        @(negedge clk);
        step();
        rst_n = 1'b1;
        // R8 reset state
        chk(io_busy == 1'b0, "R8 busy", 64'(io_busy), 64'd0);
        chk(stall == 1'b0, "R8 stall", 64'(stall), 64'd0);
        chk(latch_value == 32'h0, "R8 latch", 64'(latch_value), 64'd0);

        // R7 idle read forwarded
        for (int a = 0; a < 4; a++) begin
            cpu_req = 1; cpu_we = 0; cpu_size = 2'(a); cpu_addr = 32'h1000_0000 + 32'(a * 4 + 1);
            #1;
            chk(bus_req && !bus_we && bus_addr == cpu_addr && bus_size == 2'(a), "R7 forward",
                {bus_req, bus_we, bus_addr}, {2'b10, cpu_addr});
            chk(cpu_rdata == {cpu_addr, ~cpu_addr}, "R7 data", cpu_rdata, {cpu_addr, ~cpu_addr});
            step();
            cpu_req = 0;
            chk(!stall && !io_busy, "R7 no stall", 64'({stall, io_busy}), 64'd0);
        end

        // R1 full busy window
        d = 64'hFEDC_BA98_7654_3210;
        cpu_req = 1; cpu_we = 1; cpu_size = 2'd2; cpu_addr = 32'h40; cpu_wdata = d;
        #1;
        chk(cpu_wr_ok && bus_req && bus_wdata == d, "R1 accept", {cpu_wr_ok, bus_req}, 64'd3);
        step();
        cpu_req = 0;
        bc = 0;
        while (io_busy && bc < N + 4) begin bc++; step(); end
        chk(bc == N, "R1 busy length", 64'(bc), 64'(N));

        // sweep sizes x read offsets
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < N; k++) begin
                d = {32'hA500_0000 + 32'(k * 256 + s), 32'h5A00_0000 + 32'(k * 16 + s)};
                lat = exp_latch(s, k[0], d);
                cpu_req = 1; cpu_we = 1; cpu_size = 2'(s); cpu_addr = 32'h200 + 32'(k); cpu_wdata = d;
                #1;
                chk(cpu_wr_ok && bus_req, "R1 accept sweep", {cpu_wr_ok, bus_req}, 64'd3);
                step();
                cpu_req = 0;
                bc = 1;
                chk(io_busy == 1'b1, "R1 busy set", 64'(io_busy), 64'd1);
                if (s == 0) chk(latch_value == lat, "R3 byte place", 64'(latch_value), 64'(lat));
                else        chk(latch_value == lat, "R4 place", 64'(latch_value), 64'(lat));
                for (int i = 0; i < k; i++) begin
                    if (i == 0) begin
                        cpu_req = 1; cpu_we = 1; cpu_size = 2'((s + 1) % 4); cpu_wdata = ~d;
                        #1;
                        chk(!cpu_wr_ok && !bus_req, "R2 reject busy", {cpu_wr_ok, bus_req}, 64'd0);
                    end
                    step();
                    cpu_req = 0;
                    bc++;
                    chk(io_busy && latch_value == lat, "R2 latch kept", 64'(latch_value), 64'(lat));
                end
                cpu_req = 1; cpu_we = 0; cpu_size = 2'(s); cpu_addr = 32'h300;
                #1;
                chk(cpu_rdata == exp_slice(s, lat), "R5 slice", cpu_rdata, exp_slice(s, lat));
                chk(!bus_req, "R6 no bus", 64'(bus_req), 64'd0);
                step();
                cpu_req = 0;
                sc = 0;
                while (stall && sc < N + 4) begin
                    chk(io_busy == 1'b1, "R6 busy in stall", 64'(io_busy), 64'd1);
                    if (sc == 0) begin
                        cpu_req = 1; cpu_we = 1; cpu_size = 2'd2; cpu_wdata = 64'h1111;
                        #1;
                        chk(!cpu_wr_ok && !bus_req, "R2 reject stall", {cpu_wr_ok, bus_req}, 64'd0);
                    end
                    step();
                    cpu_req = 0;
                    sc++;
                end
                chk(sc == N - k - 1, "R6 stall length", 64'(sc), 64'(N - k - 1));
                chk(!io_busy, "R6 busy drops with stall", 64'(io_busy), 64'd0);
                chk(latch_value == lat, "R2 latch after stall", 64'(latch_value), 64'(lat));
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule